// File: doc/BRIEF.md
# PRBS7 Test Pattern Generator

This block produces a serial pseudo-random bit stream for bit-error testing. A seven-stage shift register advances once per enabled clock. Stage 1 takes the XOR of stages 6 and 7, which gives the generator polynomial 1 + x^6 + x^7. The serial bit is taken from stage 7. From any nonzero starting value the stream repeats every 127 bits.

A 7-bit seed is written with a load strobe. An all-zero seed would lock the register at zero. Such a seed is therefore replaced by 7'b0000001, and a seed-error flag is raised. A marker output pulses when the register is back at the state captured at the last load, so a receiver or a counter can align to the period.

Top module: `prbs7_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts 7'b1111111 in the register, so dout is 1. It clears seed_err and period_start.
- R2: When load is high at an edge, the seed is written into the register at that edge, even if en is also high. After the edge, dout equals seed[6]. The next seven samples of dout, taken across enabled shifts, give seed[6] down to seed[0].
- R3: A load of 7'b0000000 sets seed_err and writes 7'b0000001 in place of the seed. Any later load of a nonzero seed, or a reset, clears seed_err.
- R4: On each edge with en high and load low, the register shifts one stage toward stage 7. Stage 1 takes stage 6 XOR stage 7, and dout is stage 7.
- R5: On an edge with en and load both low, the register and dout keep their values.
- R6: period_start is high for one cycle after each load. It is also high after each enabled shift that brings the register back to the state captured at the last load, which happens every 127 enabled shifts. It is low in every other cycle.
- R7: Within one period, all 127 nonzero 7-bit windows of dout appear exactly once. The longest run of 1s is 7 and the longest run of 0s is 6.
- R8: The register never holds all zeros, so dout never sticks at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Seed write strobe, takes priority over en |
| en | input | 1 | Shift enable |
| seed | input | 7 | Seed value; bit 6 is stage 7 |
| dout | output | 1 | Serial pattern bit (stage 7) |
| seed_err | output | 1 | Last loaded seed was all zeros |
| period_start | output | 1 | One-cycle marker at each period boundary |

## Verification
The hardest condition to reach from the ports is the full-period property. It requires 127 consecutive enabled shifts from a known state, followed by proof that every nonzero register state occurred exactly once, even though the register cannot be read directly. The stimulus loads the all-ones seed and enables shifting for two whole periods. The bench then rebuilds each state from sliding 7-bit windows of dout, marks each rebuilt state in a seen table, and measures the run lengths on the same capture. The period marker is also timed against the count of enabled shifts since the load, including a run where holds are mixed into the enable pattern.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int W      = 7;
  localparam int TAP_HI = 7;
  localparam int TAP_LO = 6;
  typedef logic [W-1:0] state_t;
  localparam state_t RESET_SEED = '1;
  localparam state_t SUBST_SEED = state_t'(1);

  // one shift step: stage k is bit k-1, feedback enters stage 1
  function automatic state_t step(input state_t s);
    return {s[W-2:0], s[TAP_HI-1] ^ s[TAP_LO-1]};
  endfunction
endpackage

// File: rtl/prbs7_seed_guard.sv
module prbs7_seed_guard
  import prbs7_pkg::*;
(
  input  state_t seed,
  output state_t safe_seed,
  output logic   is_zero
);
  always_comb begin
    is_zero   = (seed == '0);
    safe_seed = is_zero ? SUBST_SEED : seed;
  end
endmodule

// File: rtl/prbs7_shift_core.sv
module prbs7_shift_core
  import prbs7_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   en,
  input  state_t load_val,
  output state_t state_q,
  output state_t state_nx
);
  always_comb state_nx = step(state_q);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= RESET_SEED;
    else if (load) state_q <= load_val;
    else if (en)   state_q <= state_nx;
  end
endmodule

// File: rtl/prbs7_period_mark.sv
module prbs7_period_mark
  import prbs7_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   en,
  input  state_t load_val,
  input  state_t state_nx,
  output logic   mark
);
  state_t ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= RESET_SEED;
      mark  <= 1'b0;
    end else if (load) begin
      ref_q <= load_val;
      mark  <= 1'b1;
    end else if (en) begin
      mark  <= (state_nx == ref_q);
    end else begin
      mark  <= 1'b0;
    end
  end
endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen
  import prbs7_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] seed,
  output logic         dout,
  output logic         seed_err,
  output logic         period_start
);
  state_t safe_seed;
  logic   seed_zero;
  state_t state_q;
  state_t state_nx;

  prbs7_seed_guard u_guard (
    .seed      (seed),
    .safe_seed (safe_seed),
    .is_zero   (seed_zero)
  );

  prbs7_shift_core u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .en       (en),
    .load_val (safe_seed),
    .state_q  (state_q),
    .state_nx (state_nx)
  );

  prbs7_period_mark u_mark (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .en       (en),
    .load_val (safe_seed),
    .state_nx (state_nx),
    .mark     (period_start)
  );

  always_ff @(posedge clk) begin
    if (rst)       seed_err <= 1'b0;
    else if (load) seed_err <= seed_zero;
  end

  assign dout = state_q[W-1];
endmodule

// File: rtl/prbs7_gen_chk.sv
module prbs7_gen_chk
  import prbs7_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   load,
  input logic   en,
  input state_t seed,
  input logic   dout,
  input logic   seed_err,
  input logic   period_start,
  input state_t state_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (state_q == RESET_SEED) && !seed_err && !period_start);

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> (state_q == $past(seed)) && period_start && !seed_err);

  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> seed_err && (state_q == SUBST_SEED));

  // R4
  shift_out_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> dout == $past(state_q[W-2]));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state_q) && $stable(dout) && !period_start);

  // R6
  mark_cause_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |-> $past(load || en));

  // R8
  nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

bind prbs7_gen prbs7_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .load         (load),
  .en           (en),
  .seed         (seed),
  .dout         (dout),
  .seed_err     (seed_err),
  .period_start (period_start),
  .state_q      (state_q)
);

// File: tb/test_prbs7_gen.sv
`timescale 1ns/1ps
module test_prbs7_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic       en = 1'b0;
  logic [6:0] seed = '0;
  logic       dout, seed_err, period_start;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  prbs7_gen i_prbs7_gen (
    .clk(clk), .rst(rst), .load(load), .en(en), .seed(seed),
    .dout(dout), .seed_err(seed_err), .period_start(period_start)
  );

  // {seed, expected seed_err, expected loaded state}
  typedef struct packed { logic [6:0] sd; logic er; logic [6:0] st; } vec_t;
  localparam vec_t VEC [6] = '{
    '{7'h55, 1'b0, 7'h55},
    '{7'h00, 1'b1, 7'h01},
    '{7'h40, 1'b0, 7'h40},
    '{7'h01, 1'b0, 7'h01},
    '{7'h7F, 1'b0, 7'h7F},
    '{7'h2A, 1'b0, 7'h2A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, sample 1 ns later
  task automatic cyc(input logic r, input logic l, input logic e, input logic [6:0] s);
    @(negedge clk);
    rst = r; load = l; en = e; seed = s;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [6:0] mstep(input logic [6:0] m);
    return {m[5:0], m[5] ^ m[6]};
  endfunction

  initial begin : watchdog
    #900000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [6:0] m, rec;
    logic       cap [260];
    bit         seen [128];
    int         n, run, max1, max0, dups;

    // R1 reset state
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R1 dout", dout, 1);
    chk("R1 seed_err", seed_err, 0);
    chk("R1 period_start", period_start, 0);

    // table walk: R2 / R3 load and seed reconstruction
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, 0, VEC[i].sd);
      chk("R3 seed_err", seed_err, VEC[i].er);
      chk("R6 mark after load", period_start, 1);
      rec = '0;
      for (int k = 0; k < 7; k++) begin
        rec[6-k] = dout;
        cyc(0, 0, 1, 0);
      end
      chk("R2 loaded state", rec, VEC[i].st);
    end

    // R2 load has priority over en
    cyc(0, 1, 1, 7'h13);
    chk("R2 priority dout", dout, 0);
    rec = '0;
    for (int k = 0; k < 7; k++) begin
      rec[6-k] = dout;
      cyc(0, 0, 1, 0);
    end
    chk("R2 priority state", rec, 7'h13);

    // R3 error clears on nonzero load; R8 zero seed keeps running
    cyc(0, 1, 0, 7'h00);
    chk("R3 err set", seed_err, 1);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      cyc(0, 0, 1, 0);
      n += dout;
    end
    chk("R8 ones seen after zero seed", (n > 0), 1);
    cyc(0, 1, 0, 7'h22);
    chk("R3 err cleared", seed_err, 0);

    // R4 / R5 model compare with holds mixed in
    cyc(0, 1, 0, 7'h5B);
    m = 7'h5B;
    for (int k = 0; k < 300; k++) begin
      logic e, prev;
      e = ((k % 3) != 2);
      prev = dout;
      cyc(0, 0, e, 0);
      if (e) m = mstep(m);
      if (dout !== m[6]) chk("R4 model dout", dout, m[6]);
      if (!e && dout !== prev) chk("R5 hold", dout, prev);
    end
    chk("R4 model final", dout, m[6]);

    // R6 period: count enabled shifts until the marker
    cyc(0, 1, 0, 7'h7F);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      cyc(0, 0, ((k % 5) != 4), 0);
      if ((k % 5) != 4) n++;
      if (period_start) break;
    end
    chk("R6 period length", n, 127);

    // R7 capture two periods from all-ones
    cyc(0, 1, 0, 7'h7F);
    for (int k = 0; k < 260; k++) begin
      cap[k] = dout;
      cyc(0, 0, 1, 0);
    end
    for (int k = 0; k < 128; k++) seen[k] = 0;
    dups = 0;
    for (int i = 0; i < 127; i++) begin
      rec = '0;
      for (int b = 0; b < 7; b++) rec[6-b] = cap[i+b];
      if (seen[rec] || rec == 0) dups++;
      seen[rec] = 1;
    end
    chk("R7 unique nonzero windows", dups, 0);
    max1 = 0; max0 = 0; run = 0;
    for (int i = 0; i < 254; i++) begin
      if (i > 0 && cap[i] == cap[i-1]) run++;
      else run = 1;
      if (cap[i]) max1 = (run > max1) ? run : max1;
      else        max0 = (run > max0) ? run : max0;
    end
    chk("R7 longest ones", max1, 7);
    chk("R7 longest zeros", max0, 6);

    // R5 full hold with load low
    cyc(0, 1, 0, 7'h3C);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 7'h11);
      chk("R5 hold dout", dout, 0);
      chk("R6 mark low in hold", period_start, 0);
    end

    // R1 reset mid-run after zero seed
    cyc(0, 1, 0, 7'h00);
    cyc(1, 0, 1, 0);
    chk("R1 mid-run seed_err", seed_err, 0);
    chk("R1 mid-run dout", dout, 1);
    chk("R1 mid-run mark", period_start, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule